// File: doc/BRIEF.md
# Double-Precision NaN Classify and Quiet Unit

This block sorts a binary floating-point operand into one of six classes and repairs signalling NaNs. The classes are zero, denormal, normal, infinity, quiet NaN and signalling NaN. It is purely combinational. The operand's class, its replacement value and an invalid-operation flag all follow the inputs with no clock and no stored state. The exponent and fraction widths are parameters, and the defaults give the 64-bit double-precision layout: 1 sign bit, 11 exponent bits and 52 fraction bits.

A single mode input chooses between two NaN conventions.

- **Newer convention** (mode input high): a NaN whose top fraction bit is clear is signalling. It is quieted by setting that bit, and the sign and payload are kept.
- **Legacy convention** (mode input low): a NaN whose top fraction bit is set is signalling. It is replaced outright by a fixed default NaN.

In both conventions a signalling NaN raises the invalid flag. Every other operand passes to the result unchanged with the flag low. Arithmetic, trap enables and any status register live elsewhere. The mode bit and the flag are plain wires.

Top module: `dp_nan_quieter`

## Requirements
- R1: An operand with exponent field zero and fraction zero is classed zero (class_o = 0), for either sign.
- R2: An operand with exponent field zero and a nonzero fraction is classed denormal (class_o = 1). An operand whose exponent field is neither all zeros nor all ones is classed normal (class_o = 2).
- R3: An operand with exponent field all ones and fraction zero is classed infinity (class_o = 3), for either sign.
- R4: An operand with exponent field all ones and a nonzero fraction is a NaN. It is classed signalling (class_o = 5) when the fraction's most significant bit XOR nan_new_i is 1, and quiet (class_o = 4) otherwise.
- R5: With nan_new_i = 1, a signalling NaN's result keeps every bit of the operand except that the fraction's most significant bit is set.
- R6: With nan_new_i = 0, a signalling NaN's result is the default NaN. That value has sign 0, exponent all ones, and a fraction with the top bit clear and all other bits set (0x7FF7FFFFFFFFFFFF at default widths).
- R7: invalid_o is 1 exactly when the operand is a signalling NaN under the current mode, and 0 for all other operands.
- R8: Every operand that is not a signalling NaN appears on result_o unchanged. This includes quiet NaNs, infinities, zeros, denormals and normals.
- R9: class_o, result_o and invalid_o depend only on the present operand and mode, with no latency and no retained state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | EXP_W+FRAC_W+1 (64) | Operand: sign in the top bit, then the exponent field, then the fraction |
| nan_new_i | input | 1 | 1 selects the newer NaN convention, 0 selects the legacy convention |
| class_o | output | 3 | Operand class: 0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signalling NaN |
| result_o | output | EXP_W+FRAC_W+1 (64) | Operand, or its quieted replacement when it is a signalling NaN |
| invalid_o | output | 1 | Invalid-operation flag, high only for a signalling NaN |

## Verification
All three results are due in the same cycle as the stimulus, because no register lies between any input and any output. The bench drives the operand and mode just after a falling clock edge and samples a couple of nanoseconds later, well before the next rising edge. A second instance with a 3-bit exponent and 4-bit fraction is swept over every operand under both modes, and each result is compared with values computed from the field arithmetic. The 64-bit instance receives directed operands at the class boundaries and at the NaN quiet-bit edge under both modes.

// File: rtl/dpnq_pkg.sv
package dpnq_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } fp_class_e;
endpackage

// File: rtl/dpnq_fields.sv
module dpnq_fields #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] op_i,
  output logic         exp_max_o,
  output logic         exp_zero_o,
  output logic         frac_zero_o,
  output logic         qbit_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f       = op_i[W-2 -: EXP_W];
  assign frac_f      = op_i[FRAC_W-1:0];
  assign exp_max_o   = &exp_f;
  assign exp_zero_o  = ~|exp_f;
  assign frac_zero_o = ~|frac_f;
  assign qbit_o      = frac_f[FRAC_W-1];
endmodule

// File: rtl/dpnq_classify.sv
module dpnq_classify
  import dpnq_pkg::*;
(
  input  logic      exp_max_i,
  input  logic      exp_zero_i,
  input  logic      frac_zero_i,
  input  logic      qbit_i,
  input  logic      nan_new_i,
  output fp_class_e class_o
);
  always_comb begin
    if (exp_zero_i)       class_o = frac_zero_i ? CLS_ZERO : CLS_DENORM;
    else if (!exp_max_i)  class_o = CLS_NORMAL;
    else if (frac_zero_i) class_o = CLS_INF;
    else                  class_o = (qbit_i ^ nan_new_i) ? CLS_SNAN : CLS_QNAN;
  end

  always_comb begin
    AST_CLASS_IN_RANGE: assert (class_o <= CLS_SNAN) else $error("class out of range"); // R1
  end
endmodule

// File: rtl/dpnq_quiet.sv
module dpnq_quiet #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] op_i,
  input  logic         is_nan_i,
  input  logic         nan_new_i,
  output logic [W-1:0] result_o,
  output logic         invalid_o
);
  // legacy default NaN: +, exponent all ones, fraction 0111..1
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  logic sig;
  assign sig       = is_nan_i & (op_i[FRAC_W-1] ^ nan_new_i);
  assign invalid_o = sig;

  always_comb begin
    result_o = op_i;
    if (sig) begin
      if (nan_new_i) result_o[FRAC_W-1] = 1'b1;
      else           result_o = DEF_NAN;
    end
  end

  always_comb begin
    AST_QUIET_BIT: assert (!sig || (result_o[FRAC_W-1] == nan_new_i))
      else $error("quieted result still signalling"); // R4
    AST_NEW_KEEPS: assert (!(sig && nan_new_i) ||
                           (result_o[W-1:FRAC_W-1] == {op_i[W-1:FRAC_W], 1'b1} &&
                            result_o[FRAC_W-2:0] == op_i[FRAC_W-2:0]))
      else $error("newer-mode quiet altered payload"); // R5
  end
endmodule

// File: rtl/dp_nan_quieter.sv
module dp_nan_quieter
  import dpnq_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] operand_i,
  input  logic         nan_new_i,
  output logic [2:0]   class_o,
  output logic [W-1:0] result_o,
  output logic         invalid_o
);
  logic      exp_max, exp_zero, frac_zero, qbit;
  fp_class_e cls;

  dpnq_fields #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_fields (
    .op_i(operand_i), .exp_max_o(exp_max), .exp_zero_o(exp_zero),
    .frac_zero_o(frac_zero), .qbit_o(qbit)
  );

  dpnq_classify i_classify (
    .exp_max_i(exp_max), .exp_zero_i(exp_zero), .frac_zero_i(frac_zero),
    .qbit_i(qbit), .nan_new_i(nan_new_i), .class_o(cls)
  );

  dpnq_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_quiet (
    .op_i(operand_i), .is_nan_i(exp_max & ~frac_zero), .nan_new_i(nan_new_i),
    .result_o(result_o), .invalid_o(invalid_o)
  );

  assign class_o = cls;

  always_comb begin
    AST_FLAG_IFF_SNAN: assert (invalid_o == (cls == CLS_SNAN))
      else $error("flag and class disagree"); // R7
    AST_PASS_THROUGH: assert (invalid_o || result_o == operand_i)
      else $error("non-signalling operand altered"); // R8
    AST_RESULT_IS_NAN: assert (!invalid_o || (&result_o[W-2 -: EXP_W] && |result_o[FRAC_W-1:0]))
      else $error("quieted result not a NaN"); // R6
  end
endmodule

// File: tb/test_dp_nan_quieter.sv
module test_dp_nan_quieter;
  localparam int SE = 3, SF = 4, SW = SE + SF + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  logic [63:0] op;
  logic        mode;
  logic [2:0]  cls;
  logic [63:0] res;
  logic        inv;

  logic [SW-1:0] s_op, s_res;
  logic          s_mode, s_inv;
  logic [2:0]    s_cls;

  dp_nan_quieter i_dp_nan_quieter (
    .operand_i(op), .nan_new_i(mode), .class_o(cls), .result_o(res), .invalid_o(inv)
  );

  dp_nan_quieter #(.EXP_W(SE), .FRAC_W(SF)) i_dp_nan_quieter_small (
    .operand_i(s_op), .nan_new_i(s_mode), .class_o(s_cls), .result_o(s_res), .invalid_o(s_inv)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic dp(input logic [63:0] o, input logic m, input logic [2:0] ec,
                    input logic [63:0] er, input logic ei, input string req);
    @(negedge clk);
    op = o; mode = m;
    #2;
    chk({req, " class"}, 64'(cls), 64'(ec));
    chk({req, " result"}, res, er);
    chk({req, " flag"}, 64'(inv), 64'(ei));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    op = '0; mode = 1'b0; s_op = '0; s_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // R9: outputs reflect the initial zero operand with no clocking involved
    #1;
    chk("R9 idle class", 64'(cls), 64'd0);
    chk("R9 idle flag", 64'(inv), 64'd0);

    dp(64'h0000000000000000, 1'b1, 3'd0, 64'h0000000000000000, 1'b0, "R1 +0");
    dp(64'h8000000000000000, 1'b0, 3'd0, 64'h8000000000000000, 1'b0, "R1 -0");
    dp(64'h0000000000000001, 1'b1, 3'd1, 64'h0000000000000001, 1'b0, "R2 min denorm");
    dp(64'h3FF0000000000000, 1'b0, 3'd2, 64'h3FF0000000000000, 1'b0, "R2 one");
    dp(64'h7FEFFFFFFFFFFFFF, 1'b1, 3'd2, 64'h7FEFFFFFFFFFFFFF, 1'b0, "R2 max normal");
    dp(64'h7FF0000000000000, 1'b1, 3'd3, 64'h7FF0000000000000, 1'b0, "R3 +inf");
    dp(64'hFFF0000000000000, 1'b0, 3'd3, 64'hFFF0000000000000, 1'b0, "R3 -inf");
    dp(64'h7FF8000000000001, 1'b1, 3'd4, 64'h7FF8000000000001, 1'b0, "R8 new qnan");
    dp(64'hFFF0000000000123, 1'b1, 3'd5, 64'hFFF8000000000123, 1'b1, "R5 new snan");
    dp(64'h7FF0000000000001, 1'b1, 3'd5, 64'h7FF8000000000001, 1'b1, "R5 new snan min");
    dp(64'h7FF8000000000000, 1'b0, 3'd5, 64'h7FF7FFFFFFFFFFFF, 1'b1, "R6 legacy snan");
    dp(64'hFFFFFFFFFFFFFFFF, 1'b0, 3'd5, 64'h7FF7FFFFFFFFFFFF, 1'b1, "R6 legacy snan neg");
    dp(64'h7FF4000000000000, 1'b0, 3'd4, 64'h7FF4000000000000, 1'b0, "R4 legacy qnan");
    dp(64'h7FF7FFFFFFFFFFFF, 1'b0, 3'd4, 64'h7FF7FFFFFFFFFFFF, 1'b0, "R8 legacy default passes");

    // R4 R7 R8: exhaustive sweep of the small instance, both modes
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < (1 << SW); v++) begin
        logic [SE-1:0] e;
        logic [SF-1:0] f;
        logic [2:0]    ec;
        logic [SW-1:0] er;
        logic          ei;
        @(negedge clk);
        s_op = SW'(v); s_mode = m[0];
        e = s_op[SW-2 -: SE];
        f = s_op[SF-1:0];
        ei = 1'b0;
        er = s_op;
        if (e == 0)                ec = (f == 0) ? 3'd0 : 3'd1;
        else if (e != {SE{1'b1}})  ec = 3'd2;
        else if (f == 0)           ec = 3'd3;
        else if ((f >> (SF-1)) != (m & 1)) begin
          ec = 3'd5; ei = 1'b1;
          if (m == 1) er = s_op | SW'(1 << (SF-1));
          else        er = SW'(((1 << SE) - 1) << SF) | SW'((1 << (SF-1)) - 1);
        end
        else ec = 3'd4;
        #2;
        chk("R4 sweep class", 64'(s_cls), 64'(ec));
        chk("R8 sweep result", 64'(s_res), 64'(er));
        chk("R7 sweep flag", 64'(s_inv), 64'(ei));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule